// File: doc/BRIEF.md
# Switchable-Redundancy Shift Register Monitor

This block is a test design for measuring how often corrupted storage bits turn into functional failures. A serial shift register of `DEPTH` stages is built three times. Each copy is fed from one internal source that repeats a short known bit sequence. When redundancy is switched on, a bitwise majority of the three copies drives the output. When it is switched off, only copy 0 drives the output. The enable is a plain run-time input, so one build covers both modes.

A checker watches the output on every cycle and compares it with the source sequence delayed by the register length. For each output bit that differs, it raises a one-cycle error pulse and increments a saturating error counter. Each copy has a flip request that inverts one selected stage for one clock. This lets a test plant an upset in a known place and see whether it reaches the output.

Top module: `tmr_shift_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it, `vote_out`, `err_pulse` and `err_count` are all 0.
- R2: The source repeats the bits 1,1,0,1 (sequence index 0 to 3). With no flips, after m clock edges since reset (m >= DEPTH), `vote_out` equals the sequence bit at index (m - DEPTH) mod 4.
- R3: A clock edge with `flip_req[i]` high inverts stage `flip_stage` of copy i while the copy shifts. Stage 0 is the input end and stage DEPTH-1 is the output end. The wrong bit is on the copy output after DEPTH-1-`flip_stage` further edges.
- R4: With `tmr_en` high, a flip in any single copy never shows at `vote_out` and produces no error pulse.
- R5: With `tmr_en` low, a flip in copy 0 shows at `vote_out` for exactly one cycle and raises `err_count` by 1.
- R6: With `tmr_en` low, flips in copies 1 and 2 have no effect on `vote_out`, `err_pulse` or `err_count`.
- R7: With `tmr_en` high, flips at the same stage of two copies on the same edge do reach `vote_out` and are counted.
- R8: `err_pulse` is high for one cycle on the cycle after each wrong output bit, once per wrong bit, and `err_count` increments on that same edge.
- R9: `err_count` saturates at 2^CNT_W-1 and holds there.
- R10: For the first DEPTH edges after reset, the checker is blanked: no pulse and no count, whatever the output shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tmr_en | input | 1 | 1 = majority of three copies, 0 = copy 0 only |
| flip_req | input | 3 | Per-copy request to invert one stage on this edge |
| flip_stage | input | $clog2(DEPTH) | Stage index that a flip request inverts |
| vote_out | output | 1 | Register output (voted or copy 0) |
| err_pulse | output | 1 | One-cycle flag per wrong output bit |
| err_count | output | CNT_W | Saturating count of wrong output bits |

## Verification
The bench builds the block with DEPTH = 8 and CNT_W = 4. The short register keeps the fill window and the travel time of a planted bit to a few cycles, so the bench can check the exact arrival cycle for an upset at any chosen stage. The 4-bit counter reaches saturation at 15 within a single burst of forced flips, which a 16-bit counter could not do inside the run length.

// File: rtl/tmr_mon_pkg.sv
`timescale 1ns/1ps
package tmr_mon_pkg;
  localparam int PAT_LEN = 4;
  localparam int PH_W    = $clog2(PAT_LEN);
  // sequence index 0..3 -> 1,1,0,1
  localparam logic [PAT_LEN-1:0] PAT_SEQ = 4'b1011;

  typedef logic [PH_W-1:0] phase_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic pat_bit(input phase_t ph);
    return PAT_SEQ[ph];
  endfunction

  // phase of the bit that entered `lag` edges ago
  function automatic phase_t lag_phase(input phase_t ph, input int unsigned lag);
    return phase_t'(ph - phase_t'(lag % PAT_LEN));
  endfunction
endpackage

// File: rtl/pattern_src.sv
`timescale 1ns/1ps
module pattern_src
  import tmr_mon_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase,
  output logic   src_bit
);
  phase_t ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_q + phase_t'(1);
  end

  assign phase   = ph_q;
  assign src_bit = pat_bit(ph_q);
endmodule

// File: rtl/shift_lane.sv
`timescale 1ns/1ps
module shift_lane #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             flip,
  input  logic [IDX_W-1:0] flip_idx,
  output logic             dout
);
  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] shifted;
  logic [DEPTH-1:0] upset_mask;

  assign shifted    = {sr_q[DEPTH-2:0], din};
  assign upset_mask = flip ? (DEPTH'(1) << flip_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= shifted ^ upset_mask;
  end

  assign dout = sr_q[DEPTH-1];
endmodule

// File: rtl/maj_voter.sv
`timescale 1ns/1ps
module maj_voter
  import tmr_mon_pkg::*;
(
  input  logic       tmr_en,
  input  logic [2:0] lane_out,
  output logic       vote
);
  always_comb begin
    if (tmr_en) vote = maj3(lane_out[0], lane_out[1], lane_out[2]);
    else        vote = lane_out[0];
  end
endmodule

// File: rtl/out_checker.sv
`timescale 1ns/1ps
module out_checker
  import tmr_mon_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           phase,
  input  logic             obs,
  output logic             armed,
  output logic             expect_bit,
  output logic             mismatch,
  output logic             err_pulse,
  output logic [CNT_W-1:0] err_count
);
  localparam logic [FILL_W-1:0] FILL_DONE = FILL_W'(DEPTH);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  logic [FILL_W-1:0] fill_q;
  logic              pulse_q;
  logic [CNT_W-1:0]  cnt_q;

  assign armed      = (fill_q == FILL_DONE);
  assign expect_bit = pat_bit(lag_phase(phase, DEPTH));
  assign mismatch   = armed && (obs != expect_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q  <= '0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (!armed) fill_q <= fill_q + FILL_W'(1);
      pulse_q <= mismatch;
      if (mismatch && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign err_pulse = pulse_q;
  assign err_count = cnt_q;
endmodule

// File: rtl/tmr_shift_monitor.sv
`timescale 1ns/1ps
module tmr_shift_monitor
  import tmr_mon_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic [2:0]       flip_req,
  input  logic [IDX_W-1:0] flip_stage,
  output logic             vote_out,
  output logic             err_pulse,
  output logic [CNT_W-1:0] err_count
);
  phase_t     src_phase;
  logic       src_bit;
  logic [2:0] lane_out;
  logic       chk_armed;
  logic       chk_expect;
  logic       chk_mismatch;

  pattern_src u_src (
    .clk(clk), .rst_n(rst_n), .phase(src_phase), .src_bit(src_bit)
  );

  for (genvar g = 0; g < 3; g++) begin : g_lane
    shift_lane #(.DEPTH(DEPTH)) u_lane (
      .clk(clk), .rst_n(rst_n), .din(src_bit),
      .flip(flip_req[g]), .flip_idx(flip_stage), .dout(lane_out[g])
    );
  end

  maj_voter u_vote (
    .tmr_en(tmr_en), .lane_out(lane_out), .vote(vote_out)
  );

  out_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .phase(src_phase), .obs(vote_out),
    .armed(chk_armed), .expect_bit(chk_expect), .mismatch(chk_mismatch),
    .err_pulse(err_pulse), .err_count(err_count)
  );
endmodule

// File: rtl/tmr_shift_monitor_sva.sv
`timescale 1ns/1ps
module tmr_shift_monitor_sva #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_en,
  input logic [2:0]       lane_out,
  input logic             vote_out,
  input logic             chk_armed,
  input logic             chk_expect,
  input logic             chk_mismatch,
  input logic             err_pulse,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_SINGLE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && chk_armed && $countones(lane_out ^ {3{chk_expect}}) <= 1) |-> (vote_out == chk_expect)); // R4
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    chk_mismatch |=> err_pulse); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> (err_count == $past(err_count))); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && $past(err_count) != CNT_MAX) |-> (err_count == CNT_W'($past(err_count) + 1'b1))); // R8
  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_count) == CNT_MAX) |-> (err_count == CNT_MAX)); // R9
  AST_FILL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_armed |=> !err_pulse); // R10
endmodule

bind tmr_shift_monitor tmr_shift_monitor_sva #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .lane_out(lane_out),
  .vote_out(vote_out), .chk_armed(chk_armed), .chk_expect(chk_expect),
  .chk_mismatch(chk_mismatch), .err_pulse(err_pulse), .err_count(err_count)
);

// File: tb/test_tmr_shift_monitor.sv
`timescale 1ns/1ps
module test_tmr_shift_monitor;
  localparam int N     = 8;
  localparam int CW    = 4;
  localparam int IW    = $clog2(N);
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tmr_en = 1'b0;
  logic [2:0]    flip_req = '0;
  logic [IW-1:0] flip_stage = '0;
  logic          vote_out;
  logic          err_pulse;
  logic [CW-1:0] err_count;

  int n_checks = 0;
  int n_fail   = 0;
  int edges    = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  tmr_shift_monitor #(.DEPTH(N), .CNT_W(CW)) i_tmr_shift_monitor (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .flip_req(flip_req),
    .flip_stage(flip_stage), .vote_out(vote_out), .err_pulse(err_pulse),
    .err_count(err_count)
  );

  // the source sequence is 1,1,0,1; output lags it by N edges
  function automatic logic ref_bit(input int m);
    logic seq [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
    return seq[(m - N) % 4];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; flip_req = '0; tmr_en = 1'b0;
    repeat (3) @(negedge clk);
    check(vote_out == 0 && err_pulse == 0 && err_count == 0, "R1 in reset",
          {vote_out, err_pulse, 4'(err_count)}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vote_out == 0 && err_pulse == 0 && err_count == 0, "R1 after release",
          {vote_out, err_pulse, 4'(err_count)}, 0);
  endtask

  // plant a flip on the coming edge, then watch N+2 cycles
  task automatic plant_and_watch(input logic [2:0] lanes, input int stage,
                                 output int n_bad, output int first_bad,
                                 output int n_pulse, output int first_pulse);
    n_bad = 0; first_bad = -1; n_pulse = 0; first_pulse = -1;
    flip_req = lanes; flip_stage = IW'(stage);
    @(negedge clk);
    flip_req = '0;
    for (int j = 0; j < N + 2; j++) begin
      if (vote_out != ref_bit(edges)) begin
        n_bad++;
        if (first_bad < 0) first_bad = j;
      end
      if (err_pulse) begin
        n_pulse++;
        if (first_pulse < 0) first_pulse = j;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_blank();
    tmr_en = 1'b0;
    flip_req = 3'b001; flip_stage = IW'(N - 1);
    @(negedge clk);
    flip_req = '0;
    check(vote_out == 1'b1, "R10 planted bit visible while filling", vote_out, 1);
    for (int j = 0; j < N + 2; j++) begin
      check(err_pulse == 0, "R10 no pulse during fill", err_pulse, 0);
      @(negedge clk);
    end
    check(err_count == 0, "R10 no count during fill", err_count, 0);
  endtask

  task automatic t_pattern();
    int bad = 0;
    for (int j = 0; j < 16; j++) begin
      if (edges >= N && vote_out != ref_bit(edges)) bad++;
      if (err_pulse) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R2 clean sequence 1,1,0,1 delayed by DEPTH", bad, 0);
  endtask

  task automatic t_masked();
    int nb, fb, np, fp, c0;
    tmr_en = 1'b1;
    c0 = err_count;
    plant_and_watch(3'b010, 2, nb, fb, np, fp);
    check(nb == 0 && np == 0, "R4 copy 1 flip masked", nb + np, 0);
    plant_and_watch(3'b100, 0, nb, fb, np, fp);
    check(nb == 0 && np == 0, "R4 copy 2 flip masked", nb + np, 0);
    plant_and_watch(3'b001, N - 1, nb, fb, np, fp);
    check(nb == 0 && np == 0, "R4 copy 0 flip masked", nb + np, 0);
    check(err_count == c0, "R4 count unchanged", err_count, c0);
  endtask

  task automatic t_unprotected(input int stage);
    int nb, fb, np, fp, c0;
    tmr_en = 1'b0;
    c0 = err_count;
    plant_and_watch(3'b001, stage, nb, fb, np, fp);
    check(nb == 1, "R5 exactly one wrong bit", nb, 1);
    check(fb == N - 1 - stage, "R3 arrival cycle", fb, N - 1 - stage);
    check(np == 1 && fp == fb + 1, "R8 one pulse one cycle later", fp, fb + 1);
    check(err_count == c0 + 1, "R5 count +1", err_count, c0 + 1);
  endtask

  task automatic t_ignored();
    int nb, fb, np, fp, c0;
    tmr_en = 1'b0;
    c0 = err_count;
    plant_and_watch(3'b110, 1, nb, fb, np, fp);
    check(nb == 0 && np == 0, "R6 copies 1,2 ignored when off", nb + np, 0);
    check(err_count == c0, "R6 count unchanged", err_count, c0);
  endtask

  task automatic t_double();
    int nb, fb, np, fp, c0;
    tmr_en = 1'b1;
    c0 = err_count;
    plant_and_watch(3'b011, N - 1, nb, fb, np, fp);
    check(nb == 1 && fb == 0, "R7 double upset reaches output", fb, 0);
    check(err_count == c0 + 1, "R7 double upset counted", err_count, c0 + 1);
  endtask

  task automatic t_saturate();
    tmr_en = 1'b0;
    flip_req = 3'b001; flip_stage = IW'(N - 1);
    repeat (CMAX + 6) @(negedge clk);
    flip_req = '0;
    check(err_count == CMAX, "R9 saturated", err_count, CMAX);
    repeat (3) @(negedge clk);
    check(err_count == CMAX, "R9 holds at max", err_count, CMAX);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_blank();
    t_pattern();
    t_masked();
    t_unprotected(3);
    t_unprotected(0);
    t_unprotected(N - 1);
    t_ignored();
    t_double();
    t_pattern();
    t_saturate();
    do_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule